// File: doc/BRIEF.md
# Codec serial frame timing generator

This block produces the timing for a serial codec port from a master serial clock. While its enable input is high it drives a bit clock at half the master rate. It also drives a frame sync that marks bit 0 of every 128-bit frame, with frames following one another without gaps, and a 7-bit bit counter that gives the position inside the frame. Two independent sample-rate strobes, one for an audio codec and one for a telecom codec, each fire once every 32 × divisor master clocks. Each has its own programmable 7-bit divisor and its own lowest legal value.

Clearing the enable stops everything at the next clock edge and cuts the current frame short. It also raises a one-cycle flush pulse, which the surrounding port uses to empty its FIFOs. While disabled, every counter is held at zero. A divisor below its legal minimum raises an error flag and silences that strobe, so the output stays defined. Each channel reloads its divisor at every strobe, so a divisor written in the middle of a period takes effect from the following period.

Top module: `cft_frame_timer`

## Requirements
- R1: After reset, and whenever the block is disabled, `sclk_o`, `fsync_o`, `bitcnt_o`, `aud_stb_o`, `tel_stb_o`, `flush_o` and `div_err_o` are all 0.
- R2: Call the master clock cycles after the edge that samples `en_i` rising windows 1, 2, 3 and so on. `sclk_o` is 1 in the odd windows and 0 in the even windows, so one bit lasts two master cycles and the first bit starts high.
- R3: `bitcnt_o` equals ((k−1)/2) mod 128 in window k. It steps once per bit and wraps from 127 to 0 with no gap. `fsync_o` is 1 exactly during the two windows of bit 0 and rises together with `sclk_o`.
- R4: With an audio divisor A in the range 6..127, `aud_stb_o` is a one-cycle pulse in windows 32·A, 64·A and so on, and in no other window.
- R5: With a telecom divisor T in the range 16..127, `tel_stb_o` is a one-cycle pulse in windows 32·T, 64·T and so on, and in no other window.
- R6: Driving `en_i` low truncates the frame. From the next cycle on, `sclk_o`, `fsync_o` and `bitcnt_o` are 0. A later enable starts again at window 1 with bit 0.
- R7: `flush_o` is 1 for exactly the one cycle that follows the edge at which a running block samples `en_i` low. It is 0 at all other times.
- R8: While enabled with an audio divisor below 6 or a telecom divisor below 16, `div_err_o` is 1 and the strobe of the offending channel stays 0.
- R9: A channel samples its divisor at enable and again at each of its strobes. A divisor changed in the middle of a period sets the length of the period that starts at the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Port enable |
| aud_div_i | input | 7 | Audio sample-rate divisor |
| tel_div_i | input | 7 | Telecom sample-rate divisor |
| sclk_o | output | 1 | Bit clock, half the master rate |
| fsync_o | output | 1 | Frame sync, high during bit 0 |
| bitcnt_o | output | 7 | Bit position inside the frame |
| aud_stb_o | output | 1 | Audio sample strobe |
| tel_stb_o | output | 1 | Telecom sample strobe |
| flush_o | output | 1 | One-cycle FIFO flush pulse on disable |
| div_err_o | output | 1 | A loaded divisor is below its minimum |

## Verification
The first run uses the two smallest legal divisors (6 and 16). It lasts long enough to cover several frame wraps and many strobes, which separates a correct period from an off-by-one period and a correct first strobe from one that is one tick early. A second run is disabled in the middle of a frame to show truncation, the flush pulse and a restart from bit 0. Further runs load divisors one below each minimum, which must raise the error flag and give no strobes. Two more runs cover the largest divisor of 127 and a divisor changed in the middle of a period, which must take effect only at the following strobe.

// File: rtl/cft_pkg.sv
package cft_pkg;
  localparam int DIV_W    = 7;
  localparam int PRE_W    = 5;
  localparam int BIT_W    = 7;
  localparam int NUM_CH   = 2;
  localparam int CH_AUD   = 0;
  localparam int CH_TEL   = 1;
  localparam int AUD_MIN  = 6;
  localparam int TEL_MIN  = 16;

  function automatic int ch_min(input int ch);
    return (ch == CH_AUD) ? AUD_MIN : TEL_MIN;
  endfunction
endpackage

// File: rtl/cft_prescaler.sv
module cft_prescaler #(
  parameter int PRE_W = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic go_i,
  input  logic act_i,
  output logic tick_o
);
  localparam logic [PRE_W-1:0] PRE_LAST = {PRE_W{1'b1}};

  logic [PRE_W-1:0] pre_q, pre_d;
  logic             pre_en;

  always_comb begin
    pre_en = 1'b1;
    pre_d  = '0;
    if (start_i) begin
      pre_d = '0;
    end else if (go_i) begin
      pre_d = pre_q + PRE_W'(1);
    end else begin
      pre_en = (pre_q != '0);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
    end else if (pre_en) begin
      pre_q <= pre_d;
    end
  end

  assign tick_o = act_i & (pre_q == PRE_LAST);
endmodule

// File: rtl/cft_bit_timer.sv
module cft_bit_timer #(
  parameter int BIT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             go_i,
  input  logic             act_i,
  output logic             sclk_o,
  output logic             fsync_o,
  output logic [BIT_W-1:0] bitcnt_o
);
  logic             phase_q, phase_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic             tim_en;

  always_comb begin
    tim_en  = 1'b1;
    phase_d = 1'b0;
    bit_d   = '0;
    if (start_i) begin
      phase_d = 1'b0;
      bit_d   = '0;
    end else if (go_i) begin
      phase_d = ~phase_q;
      bit_d   = phase_q ? bit_q + BIT_W'(1) : bit_q;
    end else begin
      tim_en = phase_q | (bit_q != '0);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      bit_q   <= '0;
    end else if (tim_en) begin
      phase_q <= phase_d;
      bit_q   <= bit_d;
    end
  end

  assign sclk_o   = act_i & ~phase_q;
  assign fsync_o  = act_i & (bit_q == '0);
  assign bitcnt_o = bit_q;

  // R3: a new frame follows bit 127 without a gap
  assert_frame_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_i && act_i && bit_q == {BIT_W{1'b1}} && phase_q) |=> (bitcnt_o == '0 && fsync_o));
endmodule

// File: rtl/cft_rate_div.sv
module cft_rate_div #(
  parameter int DIV_W   = 7,
  parameter int MIN_DIV = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             go_i,
  input  logic             act_i,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             strobe_o,
  output logic             bad_o
);
  localparam logic [DIV_W-1:0] MIN_V = DIV_W'(MIN_DIV);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             div_en;
  logic             bad;
  logic             reload;

  assign bad    = (div_q < MIN_V);
  assign reload = tick_i & ((cnt_q == '0) | bad);

  always_comb begin
    div_en = 1'b1;
    cnt_d  = cnt_q;
    div_d  = div_q;
    if (start_i) begin
      div_d = div_i;
      cnt_d = div_i - DIV_W'(1);
    end else if (go_i) begin
      div_en = tick_i;
      if (reload) begin
        div_d = div_i;
        cnt_d = div_i - DIV_W'(1);
      end else begin
        cnt_d = cnt_q - DIV_W'(1);
      end
    end else begin
      cnt_d = '0;
      div_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      div_q <= '0;
    end else if (div_en) begin
      cnt_q <= cnt_d;
      div_q <= div_d;
    end
  end

  assign strobe_o = act_i & tick_i & (cnt_q == '0) & ~bad;
  assign bad_o    = act_i & bad;

  // R4: a strobe lasts a single cycle
  assert_strobe_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o);
  // R8: an illegal loaded divisor never produces a strobe
  assert_bad_silent_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_o |-> !strobe_o);
endmodule

// File: rtl/cft_frame_timer.sv
module cft_frame_timer
  import cft_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] aud_div_i,
  input  logic [DIV_W-1:0] tel_div_i,
  output logic             sclk_o,
  output logic             fsync_o,
  output logic [BIT_W-1:0] bitcnt_o,
  output logic             aud_stb_o,
  output logic             tel_stb_o,
  output logic             flush_o,
  output logic             div_err_o
);
  logic run_q, run_d;
  logic flush_q, flush_d;
  logic start, go, tick;
  logic [DIV_W-1:0] div_arr [NUM_CH];
  logic [NUM_CH-1:0] stb, bad;

  assign start = en_i & ~run_q;
  assign go    = en_i & run_q;

  always_comb begin
    run_d   = en_i;
    flush_d = run_q & ~en_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      flush_q <= 1'b0;
    end else begin
      run_q   <= run_d;
      flush_q <= flush_d;
    end
  end

  cft_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .go_i(go),
    .act_i(run_q), .tick_o(tick)
  );

  cft_bit_timer #(.BIT_W(BIT_W)) u_bit (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .go_i(go),
    .act_i(run_q), .sclk_o(sclk_o), .fsync_o(fsync_o), .bitcnt_o(bitcnt_o)
  );

  assign div_arr[CH_AUD] = aud_div_i;
  assign div_arr[CH_TEL] = tel_div_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    cft_rate_div #(.DIV_W(DIV_W), .MIN_DIV(ch_min(c))) u_div (
      .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .go_i(go),
      .act_i(run_q), .tick_i(tick), .div_i(div_arr[c]),
      .strobe_o(stb[c]), .bad_o(bad[c])
    );
  end

  assign aud_stb_o = stb[CH_AUD];
  assign tel_stb_o = stb[CH_TEL];
  assign div_err_o = |bad;
  assign flush_o   = flush_q;

  // R2: bit clock high phase lasts one master cycle while running
  assert_sclk_half_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && en_i) |=> !sclk_o);
  // R6: disabling idles the frame outputs on the next cycle
  assert_stop_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!sclk_o && !fsync_o && bitcnt_o == '0));
  // R7: the flush pulse never lasts two cycles
  assert_flush_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> !flush_o);
  // R1: nothing is produced while disabled
  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !$past(en_i)) |=> (!aud_stb_o && !tel_stb_o && !div_err_o));
endmodule

// File: tb/tb_cft_frame_timer.sv
module tb_cft_frame_timer;
  localparam int CLK_PERIOD = 10;

  logic       clk, rst_n, en;
  logic [6:0] adiv, tdiv;
  logic       sclk, fsync, astb, tstb, flush, derr;
  logic [6:0] bitcnt;

  int  errors = 0;
  int  checks = 0;
  bit  done = 0;
  bit  tb_run = 0;
  bit  tb_err = 0;
  int  k = 0;
  int  aq[$];
  int  tq[$];

  cft_frame_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .aud_div_i(adiv), .tel_div_i(tdiv),
    .sclk_o(sclk), .fsync_o(fsync), .bitcnt_o(bitcnt), .aud_stb_o(astb),
    .tel_stb_o(tstb), .flush_o(flush), .div_err_o(derr)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at k=%0d: actual=%0d expected=%0d", req, k, act, exp);
    end
  endtask

  // monitor: compares outputs against the bench model and the queues
  bit prev_run = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit ea, et;
      if (tb_run) begin
        k++;
        chk("R2 sclk", int'(sclk), ((k-1)%2 == 0) ? 1 : 0);
        chk("R3 bitcnt", int'(bitcnt), ((k-1)/2)%128);
        chk("R3 fsync", int'(fsync), (((k-1)/2)%128 == 0) ? 1 : 0);
        chk("R8 err", int'(derr), int'(tb_err));
      end else begin
        chk("R6 idle sclk", int'(sclk), 0);
        chk("R6 idle fsync", int'(fsync), 0);
        chk("R6 idle bitcnt", int'(bitcnt), 0);
        chk("R1 idle err", int'(derr), 0);
      end
      chk("R7 flush", int'(flush), (prev_run && !tb_run) ? 1 : 0);
      prev_run = tb_run;
      ea = tb_run && aq.size() > 0 && aq[0] == k;
      et = tb_run && tq.size() > 0 && tq[0] == k;
      if (ea) void'(aq.pop_front());
      if (et) void'(tq.pop_front());
      chk("R4 aud strobe", int'(astb), int'(ea));
      chk("R5 tel strobe", int'(tstb), int'(et));
    end
  end

  function automatic void plan_q(ref int q[$], input int d0, input int d1,
                                 input int chg, input int len, input int mn);
    int t = 0;
    int d = d0;
    if (d0 < mn) return;
    forever begin
      t += 32*d;
      if (t > len) break;
      q.push_back(t);
      d = (chg > 0 && chg < t) ? d1 : d0;
      if (d < mn) break;
    end
  endfunction

  // driver: programs a case, pushes expected strobes, runs it, disables
  task automatic run_case(input int a0, input int t0, input int len,
                          input int chg, input int a1);
    plan_q(aq, a0, a1, chg, len, 6);
    plan_q(tq, t0, t0, 0, len, 16);
    adiv = 7'(a0); tdiv = 7'(t0);
    tb_err = (a0 < 6) || (t0 < 16);
    en = 1; k = 0; tb_run = 1;
    for (int i = 1; i <= len; i++) begin
      @(negedge clk); #1;
      if (i == chg) adiv = 7'(a1);
    end
    en = 0; tb_run = 0;
    repeat (4) begin @(negedge clk); #1; end
    chk("R4 queue drained", aq.size(), 0);
    chk("R5 queue drained", tq.size(), 0);
    aq.delete(); tq.delete();
  endtask

  initial begin
    rst_n = 0; en = 0; adiv = 7'd6; tdiv = 7'd16;
    repeat (3) @(negedge clk);
    chk("R1 reset sclk", int'(sclk), 0);
    chk("R1 reset flush", int'(flush), 0);
    chk("R1 reset strobes", int'(astb | tstb), 0);
    #1 rst_n = 1;
    repeat (3) begin @(negedge clk); #1; end
    run_case(6, 16, 1100, 0, 6);      // R4 R5 minimum legal divisors, frame wraps
    run_case(9, 20, 333, 0, 9);       // R6 R7 truncated mid-frame, then restart
    run_case(5, 15, 600, 0, 5);       // R8 both below minimum
    run_case(6, 127, 4100, 0, 6);     // R5 largest divisor
    run_case(6, 16, 800, 100, 8);     // R9 mid-period change
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule